// File: doc/BRIEF.md
# Multiplexed-Address 4K x 1 Dynamic Memory Core

This block is a cycle-level, synthesizable model of a 4096-word by 1-bit dynamic memory whose twelve cell-address bits arrive in two halves over a shared 6-bit address bus. A falling row strobe captures the upper half. A falling column strobe captures the lower half together with the active-low chip select. Both strobes are active low and asynchronous to the model. The model runs on a fast system clock and detects strobe edges by comparing each strobe with its value at the previous clock.

The block supports read, early-write, delayed-write, read-modify-write and row-only refresh cycles. Its data output carries a valid flag that stands in for the high-impedance state. Every column-strobe fall turns the output off. A selected cycle turns it back on after a parameterised number of clocks. The output then holds its value until the next column-strobe fall, and row-only cycles in between leave it untouched. Refresh has no effect on the stored array.

Top module: `mux_dram4k`

## Requirements
- R1: The row half is taken from `addr` at the clock that first samples `row_stb_n` low. The column half is taken at the clock that first samples `col_stb_n` low. The cell index is {row, column}, with the row in bits 11:6.
- R2: `cs_n` is sampled at the column-strobe fall. When it is high, neither an early write nor a later write-enable fall changes the stored data.
- R3: At the clock that samples a column-strobe fall, `dout_en` goes to 0, whatever the other inputs hold.
- R4: In a selected cycle with `we_n` high at the column-strobe fall, `dout_en` becomes 1 exactly ACC_DLY clocks after the fall is sampled. `dout` then shows the addressed bit without inversion.
- R5: In a selected cycle with `we_n` low at the column-strobe fall, `din` is written at that clock. After the same access delay, `dout_en` is 1 and `dout` is 1, whatever was written.
- R6: Once `dout_en` is 1, it and `dout` keep their values until the next column-strobe fall. Cycles with only the row strobe do not change them.
- R7: In a selected cycle that began with `we_n` high, a fall of `we_n` while the column strobe stays low writes the `din` value sampled at that clock into the addressed cell.
- R8: In a cycle with `cs_n` high at the column-strobe fall, `dout_en` stays 0 until the next column-strobe fall.
- R9: Reset (`rst_n` low, asynchronous) clears `dout_en`, `dout` and every stored bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_stb_n | input | 1 | Active-low row strobe |
| col_stb_n | input | 1 | Active-low column strobe |
| addr | input | 6 | Shared row/column address bus |
| cs_n | input | 1 | Active-low chip select, sampled at the column strobe |
| we_n | input | 1 | Active-low write enable |
| din | input | 1 | Write data bit |
| dout | output | 1 | Latched read data bit |
| dout_en | output | 1 | High when the output drives; low means high impedance |

## Verification
On every cycle, the assertions check that a column-strobe fall turns off the output. They check that a driven output stays unchanged until the next such fall, that an early-write cycle presents a 1, and that an unselected cycle never turns on the output. Only the bench scenarios can show the data path: which cell an address pair selects, the exact access delay, write blocking by chip select, delayed writes during read-modify-write, and the holding of the output across row-only refresh. In each case the bench reads the data back through later cycles.

// File: rtl/mux_dram4k.sv
module mux_dram4k #(
  parameter int AW      = 6,
  parameter int ACC_DLY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          row_stb_n,
  input  logic          col_stb_n,
  input  logic [AW-1:0] addr,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          din,
  output logic          dout,
  output logic          dout_en
);
  localparam int CW    = 2 * AW;
  localparam int CELLS = 1 << CW;
  localparam int DW    = $clog2(ACC_DLY + 1);

  logic            ras_q, cas_q, we_q;
  logic [AW-1:0]   row_q, col_q;
  logic            cs_q, early_q, pend_q;
  logic [DW-1:0]   cnt_q;
  logic [CELLS-1:0] mem;
  logic            dout_q, den_q;

  wire ras_fall = ras_q & ~row_stb_n;
  wire cas_fall = cas_q & ~col_stb_n;
  wire we_fall  = we_q & ~we_n;

  wire [CW-1:0] early_idx = {row_q, addr};
  wire [CW-1:0] late_idx  = {row_q, col_q};

  wire early_wr = cas_fall & ~cs_n & ~we_n;
  wire late_wr  = ~cas_q & ~col_stb_n & we_fall & ~cs_q & ~early_q;
  wire drive    = pend_q & ~cas_fall & (cnt_q == DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
      we_q    <= 1'b1;
      row_q   <= '0;
      col_q   <= '0;
      cs_q    <= 1'b1;
      early_q <= 1'b0;
    end else begin
      ras_q <= row_stb_n;
      cas_q <= col_stb_n;
      we_q  <= we_n;
      if (ras_fall) row_q <= addr;
      if (cas_fall) begin
        col_q   <= addr;
        cs_q    <= cs_n;
        early_q <= ~we_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (early_wr) begin
      mem[early_idx] <= din;
    end else if (late_wr) begin
      mem[late_idx] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      den_q  <= 1'b0;
      dout_q <= 1'b0;
    end else if (cas_fall) begin
      den_q  <= 1'b0;
      pend_q <= ~cs_n;
      cnt_q  <= DW'(ACC_DLY);
    end else if (drive) begin
      pend_q <= 1'b0;
      den_q  <= 1'b1;
      dout_q <= early_q ? 1'b1 : mem[late_idx];
    end else if (pend_q) begin
      cnt_q <= cnt_q - DW'(1);
    end
  end

  assign dout    = dout_q;
  assign dout_en = den_q;
endmodule

// File: rtl/mux_dram4k_chk.sv
module mux_dram4k_chk (
  input logic clk,
  input logic rst_n,
  input logic col_stb_n,
  input logic dout,
  input logic dout_en,
  input logic early_q,
  input logic unsel_q
);
  a_r3_cas_opens_output: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(col_stb_n) |=> !dout_en);

  a_r6_output_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && !$fell(col_stb_n)) |=> (dout_en && $stable(dout)));

  a_r5_early_write_one: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dout_en) && early_q) |-> dout);

  a_r8_unselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en) |-> !unsel_q);
endmodule

bind mux_dram4k mux_dram4k_chk u_chk (
  .clk(clk), .rst_n(rst_n), .col_stb_n(col_stb_n), .dout(dout),
  .dout_en(dout_en), .early_q(early_q), .unsel_q(cs_q)
);

// File: tb/tb_mux_dram4k.sv
module tb_mux_dram4k;
  localparam int DLY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_stb_n = 1'b1, col_stb_n = 1'b1, cs_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [5:0] addr = '0;
  wire dout, dout_en;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  mux_dram4k #(.AW(6), .ACC_DLY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .addr(addr), .cs_n(cs_n), .we_n(we_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic open_row(input logic [5:0] r);
    @(negedge clk);
    addr = r; row_stb_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic close_cycle();
    @(negedge clk);
    row_stb_n = 1'b1; col_stb_n = 1'b1; we_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  // Falls the column strobe and checks turn-off and access timing.
  task automatic strobe_col(input logic [5:0] c, input logic sel_n, input logic wr_n,
                            input logic d, input logic exp_on, input logic exp_val,
                            input string req);
    @(negedge clk);
    addr = c; cs_n = sel_n; we_n = wr_n; din = d; col_stb_n = 1'b0;
    @(negedge clk);
    chk(dout_en == 1'b0, "R3", dout_en, 0);
    repeat (DLY - 1) @(negedge clk);
    chk(dout_en == 1'b0, "R4 delay", dout_en, 0);
    @(negedge clk);
    chk(dout_en == exp_on, req, dout_en, exp_on);
    if (exp_on) chk(dout == exp_val, req, dout, exp_val);
  endtask

  task automatic early_write(input logic [5:0] r, input logic [5:0] c, input logic d);
    open_row(r);
    strobe_col(c, 1'b0, 1'b0, d, 1'b1, 1'b1, "R5 early write shows 1");
    close_cycle();
  endtask

  task automatic read_cell(input logic [5:0] r, input logic [5:0] c, input logic v,
                           input string req);
    open_row(r);
    strobe_col(c, 1'b0, 1'b1, 1'b0, 1'b1, v, req);
    close_cycle();
  endtask

  task automatic test_reset();
    chk(dout_en == 1'b0, "R9 reset dout_en", dout_en, 0);
    chk(dout == 1'b0, "R9 reset dout", dout, 0);
    read_cell(6'd30, 6'd30, 1'b0, "R9 array cleared");
  endtask

  task automatic test_addressing();
    early_write(6'd5, 6'd9, 1'b1);
    early_write(6'd5, 6'd10, 1'b0);
    early_write(6'd63, 6'd0, 1'b1);
    read_cell(6'd5, 6'd9, 1'b1, "R1 R4 read one");
    read_cell(6'd5, 6'd10, 1'b0, "R1 R4 read zero");
    read_cell(6'd63, 6'd0, 1'b1, "R1 row high");
    read_cell(6'd0, 6'd63, 1'b0, "R1 halves not swapped");
  endtask

  task automatic test_unselected();
    open_row(6'd5);
    strobe_col(6'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 unselected stays off");
    repeat (2) @(negedge clk);
    chk(dout_en == 1'b0, "R8 still off", dout_en, 0);
    close_cycle();
    read_cell(6'd5, 6'd9, 1'b1, "R2 early write blocked");
  endtask

  task automatic test_rmw();
    open_row(6'd5);
    strobe_col(6'd10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R4 rmw read part");
    @(negedge clk);
    we_n = 1'b0; din = 1'b1;
    @(negedge clk);
    din = 1'b0;
    chk(dout == 1'b0 && dout_en, "R6 output held in write", dout, 0);
    close_cycle();
    read_cell(6'd5, 6'd10, 1'b1, "R7 delayed write stored");
    open_row(6'd5);
    strobe_col(6'd10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8 unselected read off");
    @(negedge clk);
    we_n = 1'b0; din = 1'b0;
    @(negedge clk);
    close_cycle();
    read_cell(6'd5, 6'd10, 1'b1, "R2 delayed write blocked");
  endtask

  task automatic test_refresh();
    read_cell(6'd63, 6'd0, 1'b1, "R4 read before refresh");
    open_row(6'd20);
    repeat (2) @(negedge clk);
    close_cycle();
    open_row(6'd21);
    close_cycle();
    chk(dout_en == 1'b1, "R6 refresh keeps enable", dout_en, 1);
    chk(dout == 1'b1, "R6 refresh keeps data", dout, 1);
    read_cell(6'd5, 6'd10, 1'b1, "R6 next cycle reads");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_addressing();
    test_unselected();
    test_rmw();
    test_refresh();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule